// File: doc/BRIEF.md
# Accelerometer Register Port on an I2C Target

This block sits on a two-wire I2C bus as a target for a two-axis acceleration sensor. SCL and SDA are brought into the system clock domain through synchronizers. The block finds START and STOP conditions in that domain, shifts bytes in on SCL rising edges and shifts bytes out on SCL falling edges. It drives SDA only by pulling it low, through `sda_oe`.

The upper four address bits are fixed at binary 0010. Three strap pins supply the lower three. A write carries a register index, which must be zero, and then one control byte. The control byte sets power-down, bandgap test and temperature select.

A read returns a burst in a fixed order: the control byte, then the first channel as two bytes, then the Y axis as two bytes. The first channel is the X axis, or the temperature sample when the temperature bit is set. The samples are frozen when the read address is accepted, so the high and low halves of a value always match.

Top module: `i2c_accel_target`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new address phase from any state, including inside a transfer (repeated START). A STOP (SDA rising while SCL is high) returns the block to idle with `sda_oe` low.
- R2: `sda_oe` changes only while SCL is low.
- R3: The block acknowledges the first byte after START only when its upper seven bits equal 0010 followed by `addr_strap[2:0]`. It acknowledges by holding `sda_oe` high through the 9th clock. Bit 0 of that byte selects the direction: 1 is read, 0 is write. For any other address the block acknowledges nothing until the next START.
- R4: In a write, the second byte is acknowledged only if it is 0x00. Any other value is not acknowledged, and the control byte that follows is neither acknowledged nor stored.
- R5: The third byte of a write is acknowledged and stored as the control byte. `pwr_down` follows bit 0, `bg_test` follows bit 2 and `temp_en` follows bit 3. Further write bytes are not acknowledged and leave the control byte unchanged.
- R6: After reset the control byte is 0x00, so `pwr_down`, `bg_test` and `temp_en` are low and SDA is released.
- R7: A read returns bytes MSB first in this order: the control byte, {4'b0, X[11:8]}, X[7:0], {4'b0, Y[11:8]}, Y[7:0].
- R8: When `temp_en` is set at the time the read address is accepted, the temperature sample replaces X in bytes 2 and 3.
- R9: The axis and temperature inputs are captured when a read address is acknowledged. Changes to them later in that burst do not affect the bytes returned.
- R10: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R11: Read bytes after the fifth return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level from the bus |
| sda_i | input | 1 | SDA level from the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap | input | 3 | Low three address bits |
| x_sample | input | 12 | X-axis sample |
| y_sample | input | 12 | Y-axis sample |
| t_sample | input | 12 | Temperature sample |
| pwr_down | output | 1 | Control bit 0 |
| bg_test | output | 1 | Control bit 2 |
| temp_en | output | 1 | Control bit 3 |

## Verification
A wrong bit counter or phase shows up on SDA within one byte. Either the acknowledge lands on the wrong clock, or the read data comes out shifted by a bit, and the next acknowledge sample or received byte exposes it. A wrong byte index or a bad capture shows up as a misordered or torn value in the same burst. A control register that is corrupted or written when it should not be is visible at once on the three mode outputs, and again as byte 1 of the next read.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types and constants for the I2C accelerometer target.
// Assumes: one control byte, five defined read bytes.
package i2c_tgt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RX,
        PH_TX,
        PH_HOLD
    } phase_t;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_REG,
        RX_CTRL,
        RX_DONE
    } rxkind_t;

    localparam int        BYTE_W      = 8;
    localparam int        FIELD_W     = 16;
    localparam int        IDX_W       = 3;
    localparam logic [IDX_W-1:0] LAST_IDX = 3'd5;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam int        BIT_PD      = 0;
    localparam int        BIT_BG      = 2;
    localparam int        BIT_TEMP    = 3;

endpackage

// File: rtl/i2c_tgt_linesync.sv
// Module: synchronizes SCL/SDA into clk and derives edge, START and STOP pulses.
// Assumes: STAGES >= 2; bus lines idle high; pulses are one clk wide.
module i2c_tgt_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_rdframe.sv
// Module: captures samples on read-address match and selects the byte to send.
// Assumes: AXIS_W <= 16; index 0 is the control byte, past the last index returns fill.
module i2c_tgt_rdframe
    import i2c_tgt_pkg::*;
#(
    parameter int AXIS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [7:0]        ctrl,
    input  logic [AXIS_W-1:0] x_sample,
    input  logic [AXIS_W-1:0] y_sample,
    input  logic [AXIS_W-1:0] t_sample,
    input  logic [IDX_W-1:0]  byte_idx,
    output logic [7:0]        tx_byte
);

    localparam int PAD_W = FIELD_W - AXIS_W;

    logic [AXIS_W-1:0]  snap_a;
    logic [AXIS_W-1:0]  snap_y;
    logic [FIELD_W-1:0] field_a;
    logic [FIELD_W-1:0] field_y;

    // Freeze first-channel and Y samples when a read address is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_a <= '0;
            snap_y <= '0;
        end else if (capture) begin
            snap_a <= ctrl[BIT_TEMP] ? t_sample : x_sample;
            snap_y <= y_sample;
        end
    end

    assign field_a = {{PAD_W{1'b0}}, snap_a};
    assign field_y = {{PAD_W{1'b0}}, snap_y};

    // Byte select for the read burst.
    always_comb begin
        case (byte_idx)
            3'd0:    tx_byte = ctrl;
            3'd1:    tx_byte = field_a[15:8];
            3'd2:    tx_byte = field_a[7:0];
            3'd3:    tx_byte = field_y[15:8];
            3'd4:    tx_byte = field_y[7:0];
            default: tx_byte = FILL_BYTE;
        endcase
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
// Module: byte-level target engine covering address match, write path, read shifting and ACK.
// Assumes: inputs come from i2c_tgt_linesync; no clock stretching; one control byte.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b0010,
    parameter int         STRAP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic [7:0]         tx_byte,
    output logic               sda_oe,
    output logic               capture,
    output logic [IDX_W-1:0]   byte_idx,
    output logic [7:0]         ctrl_q
);

    phase_t     phase;
    rxkind_t    kind;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic       ack_drv;
    logic       rd_dir;
    logic       mack_n;
    logic       addr_hit;
    logic       byte_end;
    logic       ack_end;

    assign addr_hit = (shreg[7:1] == {ADDR_HI, addr_strap});
    assign byte_end = scl_fall && (cnt == 4'd8);
    assign ack_end  = scl_fall && (cnt == 4'd9);
    assign capture  = (phase == PH_RX) && byte_end && (kind == RX_ADDR)
                      && addr_hit && shreg[0];

    // Main bus sequencer: START/STOP override, then per-phase bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            kind     <= RX_ADDR;
            cnt      <= '0;
            shreg    <= '0;
            txsh     <= '1;
            ack_drv  <= 1'b0;
            rd_dir   <= 1'b0;
            mack_n   <= 1'b1;
            byte_idx <= '0;
            ctrl_q   <= '0;
        end else if (start_det) begin
            phase   <= PH_RX;
            kind    <= RX_ADDR;
            cnt     <= '0;
            ack_drv <= 1'b0;
            rd_dir  <= 1'b0;
        end else if (stop_det) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            ack_drv <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (scl_rise && cnt < 4'd8) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_end) begin
                        cnt <= 4'd9;
                        case (kind)
                            RX_ADDR: begin
                                if (addr_hit) begin
                                    ack_drv  <= 1'b1;
                                    rd_dir   <= shreg[0];
                                    byte_idx <= '0;
                                end else begin
                                    phase <= PH_HOLD;
                                end
                            end
                            RX_REG: begin
                                if (shreg == 8'h00) ack_drv <= 1'b1;
                                else                phase   <= PH_HOLD;
                            end
                            RX_CTRL: begin
                                ctrl_q  <= shreg;
                                ack_drv <= 1'b1;
                            end
                            default: phase <= PH_HOLD;
                        endcase
                    end else if (ack_end) begin
                        ack_drv <= 1'b0;
                        cnt     <= '0;
                        if (kind == RX_ADDR && rd_dir) begin
                            phase    <= PH_TX;
                            txsh     <= tx_byte;
                            byte_idx <= byte_idx + 3'd1;
                        end else begin
                            case (kind)
                                RX_ADDR: kind <= RX_REG;
                                RX_REG:  kind <= RX_CTRL;
                                default: kind <= RX_DONE;
                            endcase
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall && cnt < 4'd8) begin
                        txsh <= {txsh[6:0], 1'b1};
                        cnt  <= cnt + 4'd1;
                    end else if (scl_rise && cnt == 4'd8) begin
                        mack_n <= sda_lvl;
                    end else if (byte_end) begin
                        if (!mack_n) begin
                            txsh <= tx_byte;
                            cnt  <= '0;
                            if (byte_idx != LAST_IDX) byte_idx <= byte_idx + 3'd1;
                        end else begin
                            phase <= PH_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Open-drain drive: ACK pulse or a zero data bit during transmit.
    assign sda_oe = ack_drv | ((phase == PH_TX) && (cnt < 4'd8) && !txsh[7]);

endmodule

// File: rtl/i2c_accel_target.sv
// Module: top of the I2C accelerometer target; wires sync, engine and read frame.
// Assumes: SDA open drain (sda_oe=1 pulls low); samples are stable relative to clk.
module i2c_accel_target
    import i2c_tgt_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         AXIS_W      = 12,
    parameter int         STRAP_W     = 3,
    parameter logic [3:0] ADDR_HI     = 4'b0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic [AXIS_W-1:0] x_sample,
    input  logic [AXIS_W-1:0] y_sample,
    input  logic [AXIS_W-1:0] t_sample,
    output logic              pwr_down,
    output logic              bg_test,
    output logic              temp_en
);

    logic             sda_lvl;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             capture;
    logic [IDX_W-1:0] byte_idx;
    logic [7:0]       tx_byte;
    logic [7:0]       ctrl_q;

    i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_engine #(.ADDR_HI(ADDR_HI), .STRAP_W(STRAP_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_strap (addr_strap),
        .tx_byte    (tx_byte),
        .sda_oe     (sda_oe),
        .capture    (capture),
        .byte_idx   (byte_idx),
        .ctrl_q     (ctrl_q)
    );

    i2c_tgt_rdframe #(.AXIS_W(AXIS_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .ctrl     (ctrl_q),
        .x_sample (x_sample),
        .y_sample (y_sample),
        .t_sample (t_sample),
        .byte_idx (byte_idx),
        .tx_byte  (tx_byte)
    );

    assign pwr_down = ctrl_q[BIT_PD];
    assign bg_test  = ctrl_q[BIT_BG];
    assign temp_en  = ctrl_q[BIT_TEMP];

endmodule

// File: rtl/i2c_accel_target_chk.sv
// Module: protocol checker bound into i2c_accel_target.
// Assumes: the master changes SDA only while SCL is low, as the bus requires.
module i2c_accel_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic pwr_down,
    input logic bg_test,
    input logic temp_en
);

    // R2
    sda_low_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R5
    ctrl_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({pwr_down, bg_test, temp_en}) |-> $past(scl_fall));

endmodule

bind i2c_accel_target i2c_accel_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .pwr_down  (pwr_down),
    .bg_test   (bg_test),
    .temp_en   (temp_en)
);

// File: tb/i2c_accel_target_bench.sv
// Bench: directed I2C master scenarios against i2c_accel_target.
module i2c_accel_target_bench;

    localparam int Q = 10;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] MY_ADDR = {4'b0010, STRAP};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic        sda_oe;
    logic [11:0] x_s = '0;
    logic [11:0] y_s = '0;
    logic [11:0] t_s = '0;
    logic        pwr_down;
    logic        bg_test;
    logic        temp_en;
    int          n_checks = 0;
    int          n_fail = 0;
    int          r2_bad = 0;
    bit          done = 1'b0;
    logic        oe_prev = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_accel_target u_i2c_accel_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .addr_strap (STRAP),
        .x_sample   (x_s),
        .y_sample   (y_s),
        .t_sample   (t_s),
        .pwr_down   (pwr_down),
        .bg_test    (bg_test),
        .temp_en    (temp_en)
    );

    // R2 monitor: SDA drive must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe !== oe_prev)) r2_bad++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_bus; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!ack);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a); chk("R3 write addr ack", a, 1);
        send_byte(8'h00, a);           chk("R4 reg zero ack", a, 1);
        send_byte(v, a);               chk("R5 ctrl ack", a, 1);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R6 sda released", sda_oe, 0);
        chk("R6 pwr_down", pwr_down, 0);
        chk("R6 bg_test", bg_test, 0);
        chk("R6 temp_en", temp_en, 0);
    endtask

    task automatic t_write();
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a); chk("R3 addr ack", a, 1);
        send_byte(8'h00, a);           chk("R4 reg ack", a, 1);
        send_byte(8'h0D, a);           chk("R5 ctrl ack", a, 1);
        send_byte(8'h00, a);           chk("R5 extra byte nack", a, 0);
        bus_stop();
        chk("R5 pwr_down", pwr_down, 1);
        chk("R5 bg_test", bg_test, 1);
        chk("R5 temp_en", temp_en, 1);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte({4'b0010, 3'b100, 1'b0}, a); chk("R3 foreign addr nack", a, 0);
        send_byte(8'h00, a);                   chk("R3 ignored after miss", a, 0);
        send_byte(8'h00, a);                   chk("R3 ignored ctrl", a, 0);
        bus_stop();
        chk("R3 ctrl untouched", {temp_en, bg_test, pwr_down}, 3'b111);
    endtask

    task automatic t_bad_reg();
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a); chk("R3 addr ack", a, 1);
        send_byte(8'h02, a);           chk("R4 nonzero reg nack", a, 0);
        send_byte(8'h00, a);           chk("R4 ctrl after bad reg nack", a, 0);
        bus_stop();
        chk("R4 ctrl untouched", {temp_en, bg_test, pwr_down}, 3'b111);
    endtask

    task automatic t_read_plain();
        logic a;
        logic [7:0] d;
        logic [7:0] exp [6] = '{8'h00, 8'h0A, 8'hBC, 8'h01, 8'h23, 8'hFF};
        write_ctrl(8'h00);
        chk("R5 pwr_down cleared", pwr_down, 0);
        x_s = 12'hABC; y_s = 12'h123; t_s = 12'h5A5;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a); chk("R3 read addr ack", a, 1);
        for (int i = 0; i < 6; i++) begin
            recv_byte(d, i < 5);
            chk(i == 5 ? "R11 fill byte" : "R7 frame byte", d, exp[i]);
        end
        bus_stop();
    endtask

    task automatic t_read_temp();
        logic a;
        logic [7:0] d;
        logic [7:0] exp [5] = '{8'h08, 8'h05, 8'hA5, 8'h01, 8'h23};
        write_ctrl(8'h08);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a); chk("R3 read addr ack", a, 1);
        for (int i = 0; i < 5; i++) begin
            recv_byte(d, i < 4);
            chk("R8 temp frame byte", d, exp[i]);
        end
        bus_stop();
    endtask

    task automatic t_snapshot();
        logic a;
        logic [7:0] d;
        logic [7:0] exp [4] = '{8'h07, 8'hE1, 8'h04, 8'h56};
        write_ctrl(8'h00);
        x_s = 12'h7E1; y_s = 12'h456;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a); chk("R3 read addr ack", a, 1);
        recv_byte(d, 1'b1); chk("R7 ctrl byte", d, 8'h00);
        x_s = 12'h000; y_s = 12'hFFF;
        for (int i = 0; i < 4; i++) begin
            recv_byte(d, i < 3);
            chk("R9 frozen sample byte", d, exp[i]);
        end
        bus_stop();
    endtask

    task automatic t_nack_restart();
        logic a;
        logic b;
        logic [7:0] d;
        int lows = 0;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a); chk("R3 addr ack", a, 1);
        send_byte(8'h00, a);           chk("R4 reg ack", a, 1);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a); chk("R1 repeated start read ack", a, 1);
        recv_byte(d, 1'b0);            chk("R7 ctrl byte", d, 8'h00);
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            if (!b) lows++;
        end
        chk("R10 no drive after nack", lows, 0);
        bus_stop();
        qwait();
        chk("R1 idle after stop", sda_oe, 0);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_bad_addr();
        t_bad_reg();
        t_read_plain();
        t_read_temp();
        t_snapshot();
        t_nack_restart();
        chk("R2 sda drive moved while scl high", r2_bad, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule